// File: doc/BRIEF.md
# 64-bit Machine Cycle Counter

This block holds a 64-bit cycle count for a processor's control and status register file. Software sees the count as two 32-bit halves, low and high. The block adds one to the count on every clock edge unless counting is inhibited. A single synchronous write port selects a target with a 2-bit code and replaces that register at the end of the cycle. A combinational read port returns the register picked by a second 2-bit code.

The block fixes what happens when a software write meets the increment in the same cycle. A write to one half replaces only that half's next value. The other half still takes its normal update. If the low half held all ones before a low-half write, the carry still reaches the high half in that cycle. A write to the high half discards any carry from the low half, while the low half still steps.

A two-state controller handles counting. In state ST_RUN the counter advances. In state ST_HOLD it is frozen. A write to the inhibit register with data bit 0 set takes ST_RUN to ST_HOLD. A write with bit 0 clear takes ST_HOLD back to ST_RUN. Any other cycle keeps the current state. The new state governs counting from the cycle after the write.

Top module: `cyc_counter64`

## Requirements
- R1: A synchronous active-high reset clears both halves to zero and puts the controller in ST_RUN, so the inhibit register reads 0. Counting starts on the first cycle after reset is released.
- R2: A write to a half (wr_en=1, wr_sel=0 for low, 1 for high) stores wr_data unchanged at the end of that cycle, with no increment added in that cycle.
- R3: rd_data is combinational and returns the register value present in the current cycle. rd_sel=0 returns the low half, 1 the high half, 2 the inhibit register and 3 zero. After a write of zero to the low half, reads on the next two cycles return 0 and then 1.
- R4: While counting is enabled and no write occurs, the 64-bit count rises by exactly one per cycle. A read taken 9 cycles after a write of zero to the low half returns 8.
- R5: On a low-half write, the high half rises by one in that cycle if counting is enabled and the low half held all ones before the write. Back-to-back all-ones writes to the low half raise the high half once per cycle.
- R6: On a high-half write while counting is enabled, the low half still rises by one, and any carry out of the low half is discarded in favour of the written value.
- R7: When both halves are all ones and counting is enabled, the next cycle gives zero in both halves.
- R8: A write to the inhibit register (wr_sel=2) with wr_data bit 0 set freezes both halves from the next cycle onward. Only bit 0 is stored, and the other 31 bits read as zero.
- R9: A write to the inhibit register with bit 0 clear resumes counting from the cycle after the write. The write cycle itself is still frozen.
- R10: Writes to either half take effect even while counting is frozen, and the written value then holds.
- R11: A write with wr_sel=3 changes neither half nor the inhibit register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, at most one write per cycle |
| wr_sel | input | 2 | Write target: 0 low, 1 high, 2 inhibit, 3 none |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Read source: 0 low, 1 high, 2 inhibit, 3 zero |
| rd_data | output | 32 | Selected register value, combinational |

## Verification
The bench builds the block with the default half width of 32. The carry and wrap cases therefore run at their real width. Writing all-ones and near-all-ones values places the count one step from a low-half carry or a full 64-bit wrap, so these cases are reached in a few cycles instead of 2^32. The same writes, made while frozen, reach the frozen-state cases (R10, R11) quickly.

// File: rtl/cyc_pkg.sv
package cyc_pkg;

    // Target and source codes shared by the write and read ports.
    typedef enum logic [1:0] {
        SEL_LO   = 2'd0,
        SEL_HI   = 2'd1,
        SEL_INH  = 2'd2,
        SEL_NONE = 2'd3
    } csr_sel_e;

    // Counting controller states.
    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HOLD = 1'b1
    } cnt_state_e;

endpackage

// File: rtl/cyc_inhibit_fsm.sv
module cyc_inhibit_fsm
    import cyc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr_inh,
    input  logic wr_bit,
    output logic cnt_en,
    output logic inh_flag
);

    cnt_state_e state_q;
    cnt_state_e state_d;

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (wr_inh && wr_bit) begin
                    state_d = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (wr_inh && !wr_bit) begin
                    state_d = ST_RUN;
                end
            end
            default: state_d = ST_RUN;
        endcase
    end

    // Outputs.
    always_comb begin
        cnt_en   = 1'b0;
        inh_flag = 1'b0;
        unique case (state_q)
            ST_RUN:  cnt_en   = 1'b1;
            ST_HOLD: inh_flag = 1'b1;
            default: cnt_en   = 1'b1;
        endcase
    end

    // R8: a set write freezes counting from the next cycle.
    a_r8_enter_hold: assert property (@(posedge clk) disable iff (rst)
        (wr_inh && wr_bit) |=> (inh_flag && !cnt_en));

    // R9: a clear write resumes counting from the next cycle.
    a_r9_leave_hold: assert property (@(posedge clk) disable iff (rst)
        (wr_inh && !wr_bit) |=> (cnt_en && !inh_flag));

    // R11: without an inhibit write the state does not move.
    a_r11_state_kept: assert property (@(posedge clk) disable iff (rst)
        !wr_inh |=> $stable(inh_flag));

endmodule

// File: rtl/cyc_half.sv
module cyc_half #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_hit,
    input  logic [W-1:0] wr_data,
    input  logic         inc_in,
    output logic [W-1:0] q,
    output logic         all_ones
);

    logic [W-1:0] q_d;

    always_comb begin
        if (wr_hit) begin
            q_d = wr_data;
        end else begin
            q_d = q + W'(inc_in);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= q_d;
        end
    end

    assign all_ones = &q;

    // R2: the written value is stored as-is.
    a_r2_write_as_is: assert property (@(posedge clk) disable iff (rst)
        wr_hit |=> (q == $past(wr_data)));

    // R4: one step per enabled cycle.
    a_r4_single_step: assert property (@(posedge clk) disable iff (rst)
        (!wr_hit && inc_in) |=> (q == $past(q) + W'(1)));

    // R8: frozen value holds when no write arrives.
    a_r8_frozen: assert property (@(posedge clk) disable iff (rst)
        (!wr_hit && !inc_in) |=> $stable(q));

endmodule

// File: rtl/cyc_counter64.sv
module cyc_counter64
    import cyc_pkg::*;
#(
    parameter int HALF_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [HALF_W-1:0] wr_data,
    input  logic [1:0]        rd_sel,
    output logic [HALF_W-1:0] rd_data
);

    localparam int NUM_HALVES = 2;

    logic                  cnt_en;
    logic                  inh_flag;
    logic                  wr_inh;
    logic [NUM_HALVES-1:0] hit;
    logic [NUM_HALVES-1:0] inc;
    logic [NUM_HALVES-1:0] ones;
    logic [HALF_W-1:0]     half_q [NUM_HALVES];

    assign wr_inh = wr_en && (wr_sel == SEL_INH);

    cyc_inhibit_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .wr_inh   (wr_inh),
        .wr_bit   (wr_data[0]),
        .cnt_en   (cnt_en),
        .inh_flag (inh_flag)
    );

    // Carry into each half comes from the enable and the ones of all lower
    // halves; this is evaluated on the pre-write values.
    always_comb begin
        inc[0] = cnt_en;
        for (int i = 1; i < NUM_HALVES; i++) begin
            inc[i] = inc[i-1] & ones[i-1];
        end
    end

    for (genvar g = 0; g < NUM_HALVES; g++) begin : g_half
        assign hit[g] = wr_en && (wr_sel == 2'(g));

        cyc_half #(.W(HALF_W)) u_half (
            .clk      (clk),
            .rst      (rst),
            .wr_hit   (hit[g]),
            .wr_data  (wr_data),
            .inc_in   (inc[g]),
            .q        (half_q[g]),
            .all_ones (ones[g])
        );
    end

    always_comb begin
        unique case (csr_sel_e'(rd_sel))
            SEL_LO:   rd_data = half_q[0];
            SEL_HI:   rd_data = half_q[1];
            SEL_INH:  rd_data = {{(HALF_W-1){1'b0}}, inh_flag};
            SEL_NONE: rd_data = '0;
            default:  rd_data = '0;
        endcase
    end

    // R5: carry from the pre-write low value still reaches the high half.
    a_r5_carry_on_low_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_LO && cnt_en && (&half_q[0]))
        |=> (half_q[1] == $past(half_q[1]) + HALF_W'(1)));

    // R6: the low half steps and the written high value wins over the carry.
    a_r6_low_steps_on_high_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_HI && cnt_en)
        |=> (half_q[0] == $past(half_q[0]) + HALF_W'(1)
             && half_q[1] == $past(wr_data)));

    // R7: full wrap to zero.
    a_r7_wrap: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && cnt_en && (&half_q[0]) && (&half_q[1]))
        |=> (half_q[0] == '0 && half_q[1] == '0));

    // R11: reserved write target leaves everything alone while frozen.
    a_r11_reserved_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_NONE && !cnt_en)
        |=> ($stable(half_q[0]) && $stable(half_q[1]) && $stable(inh_flag)));

    // R1: reset leaves the count at zero and counting enabled.
    a_r1_reset: assert property (@(posedge clk)
        rst |=> (half_q[0] == '0 && half_q[1] == '0 && cnt_en));

endmodule

// File: tb/sim_cyc_counter64.sv
module sim_cyc_counter64;

    localparam int W = 32;

    typedef struct packed {
        logic         we;
        logic [1:0]   ws;
        logic [W-1:0] wd;
        logic [1:0]   rs;
        logic         chk;
        logic [W-1:0] ex;
        logic [3:0]   rq;
    } vec_t;

    localparam int N = 54;
    localparam logic [W-1:0] ONES = 32'hFFFF_FFFF;

    localparam vec_t VECS [N] = '{
        // R3: write zero, then read 0 and 1
        '{1'b1, 2'd0, 32'h0, 2'd0, 1'b0, 32'h0, 4'd3},
        '{1'b0, 2'd0, 32'h0, 2'd0, 1'b1, 32'h0, 4'd3},
        '{1'b0, 2'd0, 32'h0, 2'd0, 1'b1, 32'h1, 4'd3},
        // R4: write zero, eight idle cycles, read 8
        '{1'b1, 2'd0, 32'h0, 2'd0, 1'b0, 32'h0, 4'd4},
        '{1'b0, 2'd0, 32'h0, 2'd0, 1'b0, 32'h0, 4'd4},
        '{1'b0, 2'd0, 32'h0, 2'd0, 1'b0, 32'h0, 4'd4},
        '{1'b0, 2'd0, 32'h0, 2'd0, 1'b0, 32'h0, 4'd4},
        '{1'b0, 2'd0, 32'h0, 2'd0, 1'b0, 32'h0, 4'd4},
        '{1'b0, 2'd0, 32'h0, 2'd0, 1'b0, 32'h0, 4'd4},
        '{1'b0, 2'd0, 32'h0, 2'd0, 1'b0, 32'h0, 4'd4},
        '{1'b0, 2'd0, 32'h0, 2'd0, 1'b0, 32'h0, 4'd4},
        '{1'b0, 2'd0, 32'h0, 2'd0, 1'b0, 32'h0, 4'd4},
        '{1'b0, 2'd0, 32'h0, 2'd0, 1'b1, 32'h8, 4'd4},
        // R5: repeated all-ones low writes carry into the high half
        '{1'b1, 2'd0, 32'h0, 2'd0, 1'b0, 32'h0, 4'd5},
        '{1'b1, 2'd1, 32'h0, 2'd0, 1'b0, 32'h0, 4'd5},
        '{1'b1, 2'd0, ONES,  2'd0, 1'b0, 32'h0, 4'd5},
        '{1'b1, 2'd0, ONES,  2'd0, 1'b0, 32'h0, 4'd5},
        '{1'b1, 2'd0, ONES,  2'd0, 1'b0, 32'h0, 4'd5},
        '{1'b1, 2'd0, ONES,  2'd0, 1'b0, 32'h0, 4'd5},
        '{1'b1, 2'd0, ONES,  2'd0, 1'b0, 32'h0, 4'd5},
        '{1'b0, 2'd0, 32'h0, 2'd1, 1'b1, 32'h4, 4'd5},
        '{1'b0, 2'd0, 32'h0, 2'd1, 1'b1, 32'h5, 4'd5},
        '{1'b0, 2'd0, 32'h0, 2'd0, 1'b1, 32'h1, 4'd5},
        // R7: 64-bit wrap
        '{1'b1, 2'd0, 32'h0, 2'd0, 1'b0, 32'h0, 4'd7},
        '{1'b1, 2'd1, 32'h0, 2'd0, 1'b0, 32'h0, 4'd7},
        '{1'b1, 2'd0, 32'hFFFF_FFFE, 2'd0, 1'b0, 32'h0, 4'd7},
        '{1'b1, 2'd1, ONES,  2'd0, 1'b0, 32'h0, 4'd7},
        '{1'b0, 2'd0, 32'h0, 2'd1, 1'b1, ONES,  4'd7},
        '{1'b0, 2'd0, 32'h0, 2'd1, 1'b1, 32'h0, 4'd7},
        '{1'b0, 2'd0, 32'h0, 2'd0, 1'b1, 32'h1, 4'd7},
        // R6: high write discards the low carry, low still steps
        '{1'b1, 2'd0, ONES,  2'd0, 1'b0, 32'h0, 4'd6},
        '{1'b1, 2'd1, 32'h10, 2'd0, 1'b0, 32'h0, 4'd6},
        '{1'b0, 2'd0, 32'h0, 2'd1, 1'b1, 32'h10, 4'd6},
        '{1'b0, 2'd0, 32'h0, 2'd0, 1'b1, 32'h1, 4'd6},
        // R8: inhibit, write zero, reads hold at 0; only bit 0 is kept
        '{1'b1, 2'd2, 32'h1, 2'd0, 1'b0, 32'h0, 4'd8},
        '{1'b1, 2'd0, 32'h0, 2'd0, 1'b0, 32'h0, 4'd8},
        '{1'b0, 2'd0, 32'h0, 2'd0, 1'b1, 32'h0, 4'd8},
        '{1'b0, 2'd0, 32'h0, 2'd0, 1'b1, 32'h0, 4'd8},
        '{1'b1, 2'd2, ONES,  2'd2, 1'b1, 32'h1, 4'd8},
        '{1'b0, 2'd0, 32'h0, 2'd2, 1'b1, 32'h1, 4'd8},
        // R10: high write honoured while frozen
        '{1'b1, 2'd1, 32'h1234, 2'd0, 1'b0, 32'h0, 4'd10},
        '{1'b0, 2'd0, 32'h0, 2'd1, 1'b1, 32'h1234, 4'd10},
        '{1'b0, 2'd0, 32'h0, 2'd1, 1'b1, 32'h1234, 4'd10},
        // R11: reserved target write has no effect
        '{1'b1, 2'd3, 32'hFFFF, 2'd0, 1'b1, 32'h0, 4'd11},
        '{1'b0, 2'd0, 32'h0, 2'd0, 1'b1, 32'h0, 4'd11},
        '{1'b0, 2'd0, 32'h0, 2'd1, 1'b1, 32'h1234, 4'd11},
        '{1'b0, 2'd0, 32'h0, 2'd2, 1'b1, 32'h1, 4'd11},
        '{1'b0, 2'd0, 32'h0, 2'd3, 1'b1, 32'h0, 4'd3},
        // R9: clear inhibit, counting resumes a cycle later
        '{1'b1, 2'd2, 32'h0, 2'd0, 1'b1, 32'h0, 4'd9},
        '{1'b0, 2'd0, 32'h0, 2'd0, 1'b1, 32'h0, 4'd9},
        '{1'b0, 2'd0, 32'h0, 2'd0, 1'b1, 32'h1, 4'd9},
        '{1'b1, 2'd0, 32'h0, 2'd0, 1'b0, 32'h0, 4'd9},
        '{1'b0, 2'd0, 32'h0, 2'd0, 1'b1, 32'h0, 4'd9},
        '{1'b0, 2'd0, 32'h0, 2'd0, 1'b1, 32'h1, 4'd9}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_sel = 2'd0;
    logic [W-1:0] wr_data = '0;
    logic [1:0]   rd_sel = 2'd0;
    logic [W-1:0] rd_data;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    cyc_counter64 #(.HALF_W(W)) u0 (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .rd_sel  (rd_sel),
        .rd_data (rd_data)
    );

    task automatic check(input int req, input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL R%0d got=%h expected=%h", req, got, exp);
        end
    endtask

    // Drive one cycle's inputs at the falling edge, sample mid-phase.
    task automatic drive(input logic we, input logic [1:0] ws, input logic [W-1:0] wd,
                         input logic [1:0] rs);
        @(negedge clk);
        wr_en   = we;
        wr_sel  = ws;
        wr_data = wd;
        rd_sel  = rs;
        #5;
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset state of all readable registers
        repeat (2) @(posedge clk);
        drive(1'b0, 2'd0, '0, 2'd0);
        check(1, rd_data, 32'h0);
        rd_sel = 2'd1; #1;
        check(1, rd_data, 32'h0);
        rd_sel = 2'd2; #1;
        check(1, rd_data, 32'h0);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < N; i++) begin
            drive(VECS[i].we, VECS[i].ws, VECS[i].wd, VECS[i].rs);
            if (VECS[i].chk) begin
                check(int'(VECS[i].rq), rd_data, VECS[i].ex);
            end
        end

        // R1: reset mid-run clears a frozen, non-zero state
        drive(1'b1, 2'd2, 32'h1, 2'd0);
        drive(1'b1, 2'd1, 32'hABCD, 2'd0);
        @(negedge clk);
        wr_en = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        rd_sel = 2'd0; #1;
        check(1, rd_data, 32'h0);
        rd_sel = 2'd1; #1;
        check(1, rd_data, 32'h0);
        rd_sel = 2'd2; #1;
        check(1, rd_data, 32'h0);
        drive(1'b0, 2'd0, '0, 2'd0);
        check(1, rd_data, 32'h1);

        // R2: write a pattern to the low half, stored unchanged
        drive(1'b1, 2'd0, 32'h5A5A_0000, 2'd0);
        drive(1'b0, 2'd0, '0, 2'd0);
        check(2, rd_data, 32'h5A5A_0000);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule